// File: doc/BRIEF.md
# Partial-Reconfiguration Load Controller

This block is the hardware end of a partial-reconfiguration loader. Software sees four 64-bit registers on a simple synchronous bus: control, status, data and error. To run a load, software first runs a reset handshake and waits for the idle code. It then writes a region number and raises the start bit. Next it streams 32-bit bitstream words through the data register. Before each burst it reads the free credit count from the status register. Last, it raises the complete bit and waits for hardware to drop start.

Accepted words go into an internal FIFO. An external consumer drains that FIFO at its own pace through `sink_ready`. The same consumer can report CRC, image-compatibility and protocol faults while a load runs. The controller itself flags words written without a free credit, words written outside a load, and a complete request given when no load is active. Software clears all error flags by writing ones, and a reset handshake does not clear them.

The register offsets are: 0 control, 1 status, 2 data, 3 error. Reads are combinational on `reg_addr`, and writes take effect at the clock edge.

Top module: `pr_loader`

## Requirements
- R1: Writing control bit 0 = 1 (reset request) starts a reset. After RST_CYCLES cycles in the resetting state, control bit 4 (acknowledge) reads 1. When software clears bit 0, bit 4 returns to 0 one cycle later.
- R2: A reset handshake empties the FIFO, restores the credit to DEPTH, and clears the start and complete bits. The error register keeps its contents.
- R3: Status bits [1:0] read 0 when idle, 1 while a load is active, and 2 while a reset is in progress.
- R4: Control bits [11:8] hold the region number, which is driven on `pr_region`. Writing control bit 12 = 1 (start) begins a load only if the block is idle, no reset request is pending and start is clear. Otherwise the write is ignored.
- R5: Status bits [16+:CW] show the credit, equal to DEPTH minus the FIFO occupancy. A data write with start set and a nonzero credit stores bits [31:0] and lowers the credit by one.
- R6: A data write while the credit is 0 drops the word and sets error bit 4 (FIFO overflow).
- R7: A data write while start is clear drops the word and sets error bit 3 (protocol).
- R8: Writing control bit 13 = 1 while start is set raises complete. Once the FIFO is empty, start and complete both clear and the state returns to 0. A complete request while start is clear sets error bit 0 (operation).
- R9: While a load is active, the FIFO is nonempty and `sink_ready` is high, `sink_valid` is high and `sink_word` carries the oldest stored word. The word is removed at that edge, so words leave in write order.
- R10: `inj_crc`, `inj_incompat` and `inj_proto` set error bits 1, 2 and 3 while a load is active. At any other time they have no effect.
- R11: A write to the error register clears each flag whose data bit is 1. A flag that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| sink_ready | input | 1 | Consumer can take a word this cycle |
| sink_valid | output | 1 | A word is handed to the consumer this cycle |
| sink_word | output | 32 | Oldest FIFO word |
| pr_region | output | REGION_W | Region number from control |
| inj_crc | input | 1 | Consumer reports a CRC fault |
| inj_incompat | input | 1 | Consumer reports an incompatible image |
| inj_proto | input | 1 | Consumer reports a protocol fault |

## Verification
Two pairs of functions can land on the same edge. The first pair is a data write and a consumer pop on a full FIFO. The second is a fault injection and a clearing write to the error register for the same flag. The bench provokes the first by filling the FIFO with the consumer stalled, then writing once more. The rule is that the credit seen before the edge decides, so the word must be dropped and flagged. The bench provokes the second by asserting `inj_incompat` in the same cycle as a write of ones to bit 2, and expects the flag to survive. A behavioural queue model follows every cycle and judges both cases, alongside the directed checks.

// File: rtl/pr_pkg.sv
package pr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RESET = 2'd2
    } pr_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_ERR  = 2'd3;

    localparam int B_RREQ  = 0;
    localparam int B_ACK   = 4;
    localparam int B_REG   = 8;
    localparam int B_START = 12;
    localparam int B_CMPL  = 13;
    localparam int B_CRED  = 16;

    localparam int N_ERR   = 5;
    localparam int E_OP    = 0;
    localparam int E_CRC   = 1;
    localparam int E_INCMP = 2;
    localparam int E_PROTO = 3;
    localparam int E_OVF   = 4;
endpackage

// File: rtl/pr_word_fifo.sv
module pr_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    input  logic          flush_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (flush_i) begin
            ptr_d = '0;
        end else begin
            if (push_i) ptr_d.wp = ptr_q.wp + AW'(1);
            if (pop_i)  ptr_d.rp = ptr_q.rp + AW'(1);
            ptr_d.cnt = ptr_q.cnt + CW'(push_i) - CW'(pop_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[ptr_q.wp] <= data_i;
    end

    assign head_o  = mem_q[ptr_q.rp];
    assign count_o = ptr_q.cnt;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (ptr_q.cnt < CW'(DEPTH)));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (ptr_q.cnt != '0));
endmodule

// File: rtl/pr_err_flags.sv
module pr_err_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R11
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags_q) & ~flags_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/pr_loader.sv
module pr_loader
    import pr_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int RST_CYCLES = 4,
    parameter int REGION_W   = 4,
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int RCW       = $clog2(RST_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [63:0]         reg_wdata,
    output logic [63:0]         reg_rdata,
    input  logic                sink_ready,
    output logic                sink_valid,
    output logic [31:0]         sink_word,
    output logic [REGION_W-1:0] pr_region,
    input  logic                inj_crc,
    input  logic                inj_incompat,
    input  logic                inj_proto
);
    typedef struct packed {
        pr_state_e           state;
        logic                rreq;
        logic                ack;
        logic [REGION_W-1:0] region;
        logic                start;
        logic                cmpl;
        logic [RCW-1:0]      rcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic push, pop, flush;
    logic [N_ERR-1:0] err_set, err_clr, err_flags;
    logic [CW-1:0] fifo_cnt, credit;
    logic wr_ctrl, wr_data, wr_err;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign wr_err  = reg_wr && (reg_addr == A_ERR);
    assign credit  = CW'(DEPTH) - fifo_cnt;

    pr_word_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(reg_wdata[31:0]),
        .pop_i(pop), .flush_i(flush), .head_o(sink_word), .count_o(fifo_cnt)
    );

    pr_err_flags #(.N(N_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .flags_o(err_flags)
    );

    always_comb begin
        ctl_d   = ctl_q;
        err_set = '0;
        push    = 1'b0;
        flush   = 1'b0;
        err_clr = wr_err ? reg_wdata[N_ERR-1:0] : '0;
        pop     = (ctl_q.state == ST_LOAD) && sink_ready && (fifo_cnt != '0);

        if (wr_data) begin
            if (!ctl_q.start)                 err_set[E_PROTO] = 1'b1;
            else if (fifo_cnt == CW'(DEPTH))  err_set[E_OVF]   = 1'b1;
            else                              push             = 1'b1;
        end

        if (ctl_q.state == ST_LOAD) begin
            if (inj_crc)      err_set[E_CRC]   = 1'b1;
            if (inj_incompat) err_set[E_INCMP] = 1'b1;
            if (inj_proto)    err_set[E_PROTO] = 1'b1;
        end

        if (!ctl_q.rreq) ctl_d.ack = 1'b0;

        if (wr_ctrl) begin
            ctl_d.rreq   = reg_wdata[B_RREQ];
            ctl_d.region = reg_wdata[B_REG +: REGION_W];
            if (reg_wdata[B_START] && ctl_q.state == ST_IDLE && !ctl_q.rreq && !ctl_q.start) begin
                ctl_d.start = 1'b1;
                ctl_d.state = ST_LOAD;
            end
            if (reg_wdata[B_CMPL]) begin
                if (ctl_q.start) ctl_d.cmpl = 1'b1;
                else             err_set[E_OP] = 1'b1;
            end
        end

        if (ctl_q.state == ST_LOAD && ctl_q.cmpl && fifo_cnt == '0 && !push) begin
            ctl_d.state = ST_IDLE;
            ctl_d.start = 1'b0;
            ctl_d.cmpl  = 1'b0;
        end

        if (ctl_q.state == ST_RESET) begin
            flush      = 1'b1;
            ctl_d.rcnt = ctl_q.rcnt + RCW'(1);
            if (ctl_q.rcnt == RCW'(RST_CYCLES - 1)) begin
                ctl_d.state = ST_IDLE;
                ctl_d.ack   = 1'b1;
            end
        end else if (ctl_q.rreq && !ctl_q.ack) begin
            ctl_d.state = ST_RESET;
            ctl_d.rcnt  = '0;
            ctl_d.start = 1'b0;
            ctl_d.cmpl  = 1'b0;
            flush       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_RREQ]              = ctl_q.rreq;
                reg_rdata[B_ACK]               = ctl_q.ack;
                reg_rdata[B_REG +: REGION_W]   = ctl_q.region;
                reg_rdata[B_START]             = ctl_q.start;
                reg_rdata[B_CMPL]              = ctl_q.cmpl;
            end
            A_STAT: begin
                reg_rdata[1:0]           = ctl_q.state;
                reg_rdata[B_CRED +: CW]  = credit;
            end
            A_ERR:   reg_rdata[N_ERR-1:0] = err_flags;
            default: reg_rdata = '0;
        endcase
    end

    assign sink_valid = pop;
    assign pr_region  = ctl_q.region;

    logic       start_q;
    logic [1:0] state_q;
    assign start_q = ctl_q.start;
    assign state_q = ctl_q.state;

    // R1
    ack_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.ack) |-> ($past(state_q) == ST_RESET));

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> (state_q == ST_RESET || $past(fifo_cnt) == '0));
endmodule

// File: tb/sim_pr_loader.sv
module sim_pr_loader;
    localparam int DEPTH = 16;
    localparam int RSTC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        sink_ready = 1'b0;
    logic        sink_valid;
    logic [31:0] sink_word;
    logic [3:0]  pr_region;
    logic        inj_crc = 1'b0, inj_incompat = 1'b0, inj_proto = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pr_loader u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sink_ready(sink_ready),
        .sink_valid(sink_valid), .sink_word(sink_word), .pr_region(pr_region),
        .inj_crc(inj_crc), .inj_incompat(inj_incompat), .inj_proto(inj_proto)
    );

    // behavioural reference state
    int          m_state;
    logic [31:0] m_q [$];
    bit          m_start, m_cmpl, m_rreq, m_ack;
    logic [3:0]  m_region;
    logic [4:0]  m_err;
    int          m_rcnt;
    logic [63:0] last_rd;

    function automatic logic [63:0] mread(input logic [1:0] a);
        logic [63:0] v = '0;
        case (a)
            2'd0: begin
                v[0] = m_rreq; v[4] = m_ack; v[11:8] = m_region;
                v[12] = m_start; v[13] = m_cmpl;
            end
            2'd1: begin
                v[1:0] = 2'(m_state);
                v[20:16] = 5'(DEPTH - m_q.size());
            end
            2'd3: v[4:0] = m_err;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic mstep(input logic [1:0] a, input bit we, input logic [63:0] wd,
                         input bit rdy, input logic [2:0] inj);
        int   osz = m_q.size();
        bit   pushed = 0;
        logic [4:0] set = '0;
        int   ns = m_state;
        bit   nst = m_start, ncm = m_cmpl, nrq = m_rreq, nak = m_ack;
        logic [3:0] nrg = m_region;
        int   nrc = m_rcnt;
        bit   clear_q = 0;
        if (m_state == 1 && rdy && osz > 0) void'(m_q.pop_front());
        if (we && a == 2'd2) begin
            if (!m_start)          set[3] = 1'b1;
            else if (osz == DEPTH) set[4] = 1'b1;
            else begin m_q.push_back(wd[31:0]); pushed = 1; end
        end
        if (m_state == 1) begin
            if (inj[0]) set[1] = 1'b1;
            if (inj[1]) set[2] = 1'b1;
            if (inj[2]) set[3] = 1'b1;
        end
        if (!m_rreq) nak = 0;
        if (we && a == 2'd0) begin
            nrq = wd[0]; nrg = wd[11:8];
            if (wd[12] && m_state == 0 && !m_rreq && !m_start) begin nst = 1; ns = 1; end
            if (wd[13]) begin
                if (m_start) ncm = 1; else set[0] = 1'b1;
            end
        end
        if (m_state == 1 && m_cmpl && osz == 0 && !pushed) begin ns = 0; nst = 0; ncm = 0; end
        if (m_state == 2) begin
            clear_q = 1; nrc = m_rcnt + 1;
            if (m_rcnt == RSTC - 1) begin ns = 0; nak = 1; end
        end else if (m_rreq && !m_ack) begin
            ns = 2; nrc = 0; nst = 0; ncm = 0; clear_q = 1;
        end
        if (clear_q) m_q.delete();
        m_err = (m_err & ~((we && a == 2'd3) ? wd[4:0] : 5'd0)) | set;
        m_state = ns; m_start = nst; m_cmpl = ncm; m_rreq = nrq; m_ack = nak;
        m_region = nrg; m_rcnt = nrc;
    endtask

    task automatic cyc(input logic [1:0] a, input bit we, input logic [63:0] wd,
                       input bit rdy, input logic [2:0] inj);
        bit ev;
        @(negedge clk);
        reg_addr = a; reg_wr = we; reg_wdata = wd; sink_ready = rdy;
        inj_crc = inj[0]; inj_incompat = inj[1]; inj_proto = inj[2];
        #1;
        last_rd = reg_rdata;
        chk((a == 2'd0) ? "R1 ctrl" : (a == 2'd3) ? "R11 err" : "R5 stat/data", reg_rdata, mread(a));
        ev = (m_state == 1) && rdy && (m_q.size() > 0);
        chk("R9 sink_valid", 64'(sink_valid), 64'(ev));
        if (ev) chk("R9 sink_word", 64'(sink_word), 64'(m_q[0]));
        chk("R4 region", 64'(pr_region), 64'(m_region));
        mstep(a, we, wd, rdy, inj);
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        cyc(a, 1, d, 0, 3'b000);
    endtask

    task automatic rd(input logic [1:0] a);
        cyc(a, 0, 64'd0, 0, 3'b000);
    endtask

    initial begin
        m_state = 0; m_start = 0; m_cmpl = 0; m_rreq = 0; m_ack = 0;
        m_region = '0; m_err = '0; m_rcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(2'd0); chk("R3 reset ctrl", last_rd, 64'h0);
        rd(2'd1); chk("R5 reset credit", last_rd, 64'h0010_0000);
        rd(2'd3); chk("R11 reset err", last_rd, 64'h0);

        // reset handshake
        wr(2'd0, 64'h1);
        rd(2'd1); rd(2'd1); chk("R3 resetting code", last_rd, 64'h0010_0002);
        rd(2'd1); rd(2'd1); rd(2'd1);
        rd(2'd0); chk("R1 ack set", last_rd, 64'h11);
        wr(2'd0, 64'h0);
        rd(2'd0); rd(2'd0); chk("R1 ack cleared", last_rd, 64'h0);

        // data outside a load
        wr(2'd2, 64'h1234);
        rd(2'd3); chk("R7 protocol flag", last_rd, 64'h8);
        wr(2'd3, 64'h8);
        rd(2'd3); chk("R11 w1c", last_rd, 64'h0);

        // start with region 5
        wr(2'd0, 64'h1500);
        rd(2'd1); chk("R3 loading code", last_rd, 64'h0010_0001);
        chk("R4 region out", 64'(pr_region), 64'h5);

        // fill with consumer stalled
        for (int i = 0; i < DEPTH; i++) wr(2'd2, 64'hA000_0000 + 64'(i));
        rd(2'd1); chk("R5 credit exhausted", last_rd, 64'h1);
        // write on full with consumer ready in the same cycle
        cyc(2'd2, 1, 64'hDEAD, 1, 3'b000);
        rd(2'd3); chk("R6 overflow flag", last_rd, 64'h10);

        // injection during a load
        cyc(2'd1, 0, 64'd0, 0, 3'b001);
        rd(2'd3); chk("R10 crc flag", last_rd, 64'h12);
        wr(2'd3, 64'h12);

        // complete and drain
        wr(2'd0, 64'h3500);
        for (int i = 0; i < 20; i++) cyc(2'd0, 0, 64'd0, 1, 3'b000);
        rd(2'd0); chk("R8 start released", last_rd, 64'h0500);
        rd(2'd1); chk("R8 idle after drain", last_rd, 64'h0010_0000);

        // injection while idle ignored
        cyc(2'd3, 0, 64'd0, 1, 3'b111);
        rd(2'd3); chk("R10 idle injection ignored", last_rd, 64'h0);
        // complete outside a load
        wr(2'd0, 64'h2500);
        rd(2'd3); chk("R8 operation flag", last_rd, 64'h1);
        wr(2'd3, 64'h1);

        // start ignored while reset request pending
        wr(2'd0, 64'h0501);
        for (int i = 0; i < 7; i++) rd(2'd1);
        wr(2'd0, 64'h1501);
        rd(2'd0); chk("R4 start ignored", last_rd, 64'h0511);
        wr(2'd0, 64'h0500); rd(2'd0); rd(2'd0);

        // reset in the middle of a load
        wr(2'd0, 64'h1500);
        for (int i = 0; i < 3; i++) wr(2'd2, 64'hB000_0000 + 64'(i));
        cyc(2'd1, 0, 64'd0, 0, 3'b100);
        wr(2'd0, 64'h1501);
        for (int i = 0; i < 7; i++) rd(2'd1);
        rd(2'd1); chk("R2 credit restored", last_rd, 64'h0010_0000);
        rd(2'd0); chk("R2 start cleared", last_rd, 64'h0511);
        rd(2'd3); chk("R2 errors kept", last_rd, 64'h8);
        wr(2'd0, 64'h0500); rd(2'd0); rd(2'd0);

        // set wins over clear
        wr(2'd0, 64'h1500);
        cyc(2'd3, 1, 64'h4, 0, 3'b010);
        rd(2'd3); chk("R11 set beats clear", last_rd, 64'hC);
        wr(2'd3, 64'hC);
        wr(2'd0, 64'h3500);
        rd(2'd1); rd(2'd1); chk("R8 empty completion", last_rd, 64'h0010_0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule